// File: doc/BRIEF.md
# Issue Queue Tag Wakeup Array

This block is the holding window of an out-of-order issue stage. Each slot keeps one waiting instruction with two source operands. Each operand has a physical register tag and a ready flag. On every cycle, the functional units broadcast the destination tags of the instructions they are issuing, up to `IW` tags per cycle, one per unit. Each slot compares both of its operand tags against all of those tags in parallel. A hit sets that operand's ready flag, and the flag then stays set. Once both flags of a valid slot are set, the slot raises its issue request line. An external selector answers with a grant, and the granted slot is released.

New instructions arrive on a valid/ready dispatch port. `disp_ready` is high whenever at least one slot is empty. A transfer takes place on a clock edge where `disp_valid` and `disp_ready` are both high. While `disp_ready` is low, the producer must hold its instruction and keep `disp_valid` asserted. A beat offered while `disp_ready` is low is not taken. The broadcast and grant pins have no handshake.

Top module: `iq_wakeup_array`

## Requirements
- R1: After reset every slot is empty, all `req` bits are 0 and `disp_ready` is 1.
- R2: A dispatch beat accepted at a clock edge is written into the empty slot with the lowest index. That slot is valid from that edge onward.
- R3: Each stored operand tag is compared against every broadcast slot k, whose tag sits at bits `[k*TAG_W +: TAG_W]` of `bc_tag`, in the same cycle. An equal, valid broadcast sets that operand's ready flag at the edge.
- R4: A ready flag, once set, stays set until its slot is freed, even when no broadcast repeats the tag.
- R5: `req[i]` is 1 exactly when slot i is valid and both of its operands are ready. It rises in the cycle after the edge that completed those conditions.
- R6: A broadcast slot whose `bc_valid` bit is 0 never matches, whatever its tag.
- R7: A dispatched operand is stored as ready if its dispatch ready flag is 1, or if its tag equals a valid broadcast tag in the same cycle.
- R8: A `grant[i]` that is high while `req[i]` is high frees slot i at that edge. `req[i]` is 0 from the next cycle on, and the slot can be allocated again.
- R9: A `grant[i]` given to a slot that is not requesting has no effect. The slot keeps its contents and readiness.
- R10: `disp_ready` is 0 when all slots are valid, and a beat offered then is dropped. A slot freed in the same cycle raises `disp_ready` only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch beat offered |
| disp_ready | output | 1 | At least one slot is empty |
| disp_tag_l | input | TAG_W | Left source tag |
| disp_rdy_l | input | 1 | Left source already available |
| disp_tag_r | input | TAG_W | Right source tag |
| disp_rdy_r | input | 1 | Right source already available |
| bc_valid | input | IW | Per-slot broadcast valid |
| bc_tag | input | IW*TAG_W | Broadcast destination tags, slot k at `[k*TAG_W +: TAG_W]` |
| grant | input | ENTRIES | One bit per slot, frees a requesting slot |
| req | output | ENTRIES | One bit per slot, both operands ready |

## Verification
Every result is due exactly one edge after the stimulus that causes it. A dispatch, a wakeup broadcast or a grant presented before edge n shows up on `req` and `disp_ready` just after edge n, because these outputs are decoded from slot registers alone. The bench drives each stimulus for exactly one cycle a little after an edge. It then samples two time units after the next edge, so each check reads the single register update under test and nothing later. Because allocation always takes the lowest empty slot, the expected `req` pattern is known as an exact bit mask in every scenario.

// File: rtl/iq_wake_pkg.sv
package iq_wake_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_TAG_W   = 6;
  localparam int unsigned DEF_IW      = 2;

  typedef enum logic [0:0] {
    OPND_LEFT  = 1'b0,
    OPND_RIGHT = 1'b1
  } opnd_side_e;
endpackage

// File: rtl/iq_tag_match.sv
module iq_tag_match #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned IW    = 2
) (
  input  logic [TAG_W-1:0]    probe,
  input  logic [IW-1:0]       bc_valid,
  input  logic [IW*TAG_W-1:0] bc_tag,
  output logic                hit
);
  logic [IW-1:0] hit_vec;

  for (genvar k = 0; k < IW; k++) begin : g_slot
    assign hit_vec[k] = bc_valid[k] && (bc_tag[k*TAG_W +: TAG_W] == probe);
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int unsigned ENTRIES = 16
) (
  input  logic [ENTRIES-1:0] occupied,
  output logic [ENTRIES-1:0] pick,
  output logic               any_free
);
  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!occupied[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign any_free = ~&occupied;
endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_wake_pkg::*;
#(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned IW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [TAG_W-1:0]    wr_tag_l,
  input  logic                wr_rdy_l,
  input  logic [TAG_W-1:0]    wr_tag_r,
  input  logic                wr_rdy_r,
  input  logic [IW-1:0]       bc_valid,
  input  logic [IW*TAG_W-1:0] bc_tag,
  input  logic                grant,
  output logic                vld,
  output logic                req
);
  logic [TAG_W-1:0] tag_q [2];
  logic [1:0]       rdy_q;
  logic [1:0]       hit;

  for (genvar s = 0; s < 2; s++) begin : g_opnd
    iq_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match (
      .probe    (tag_q[s]),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .hit      (hit[s])
    );
  end

  assign req = vld && (&rdy_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= 1'b0;
      rdy_q    <= '0;
      tag_q[0] <= '0;
      tag_q[1] <= '0;
    end else if (wr_en) begin
      vld                <= 1'b1;
      tag_q[OPND_LEFT]   <= wr_tag_l;
      tag_q[OPND_RIGHT]  <= wr_tag_r;
      rdy_q[OPND_LEFT]   <= wr_rdy_l;
      rdy_q[OPND_RIGHT]  <= wr_rdy_r;
    end else begin
      if (grant && req) begin
        vld   <= 1'b0;
        rdy_q <= '0;
      end else if (vld) begin
        rdy_q <= rdy_q | hit;
      end
    end
  end
endmodule

// File: rtl/iq_wakeup_array.sv
module iq_wakeup_array
  import iq_wake_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned TAG_W   = DEF_TAG_W,
  parameter int unsigned IW      = DEF_IW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                disp_valid,
  output logic                disp_ready,
  input  logic [TAG_W-1:0]    disp_tag_l,
  input  logic                disp_rdy_l,
  input  logic [TAG_W-1:0]    disp_tag_r,
  input  logic                disp_rdy_r,
  input  logic [IW-1:0]       bc_valid,
  input  logic [IW*TAG_W-1:0] bc_tag,
  input  logic [ENTRIES-1:0]  grant,
  output logic [ENTRIES-1:0]  req
);
  logic [ENTRIES-1:0] ent_vld;
  logic [ENTRIES-1:0] pick;
  logic               accept;
  logic               byp_l;
  logic               byp_r;

  iq_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .occupied (ent_vld),
    .pick     (pick),
    .any_free (disp_ready)
  );

  assign accept = disp_valid && disp_ready;

  iq_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_byp_l (
    .probe    (disp_tag_l),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .hit      (byp_l)
  );

  iq_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_byp_r (
    .probe    (disp_tag_r),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .hit      (byp_r)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    iq_entry #(.TAG_W(TAG_W), .IW(IW)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (accept && pick[i]),
      .wr_tag_l (disp_tag_l),
      .wr_rdy_l (disp_rdy_l || byp_l),
      .wr_tag_r (disp_tag_r),
      .wr_rdy_r (disp_rdy_r || byp_r),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .grant    (grant[i]),
      .vld      (ent_vld[i]),
      .req      (req[i])
    );
  end
endmodule

// File: rtl/iq_wakeup_array_chk.sv
module iq_wakeup_array_chk #(
  parameter int unsigned ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_valid,
  input logic               disp_ready,
  input logic [ENTRIES-1:0] grant,
  input logic [ENTRIES-1:0] req,
  input logic [ENTRIES-1:0] ent_vld
);
  a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_vld) |-> !disp_ready);

  a_r2_fill_count: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && ((grant & req) == '0)) |=>
      ($countones(ent_vld) == $past($countones(ent_vld)) + 1));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    a_r4_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && !grant[i]) |=> req[i]);

    a_r8_grant_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && grant[i]) |=> !req[i]);

    a_r5_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ent_vld[i] |-> !req[i]);
  end
endmodule

bind iq_wakeup_array iq_wakeup_array_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .grant      (grant),
  .req        (req),
  .ent_vld    (ent_vld)
);

// File: tb/iq_wakeup_array_tb_top.sv
module iq_wakeup_array_tb_top;
  localparam int N  = 16;
  localparam int TW = 6;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          disp_valid;
  logic          disp_ready;
  logic [TW-1:0] disp_tag_l, disp_tag_r;
  logic          disp_rdy_l, disp_rdy_r;
  logic [IW-1:0] bc_valid;
  logic [IW*TW-1:0] bc_tag;
  logic [N-1:0]  grant;
  logic [N-1:0]  req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  iq_wakeup_array #(.ENTRIES(N), .TAG_W(TW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tag_l(disp_tag_l), .disp_rdy_l(disp_rdy_l),
    .disp_tag_r(disp_tag_r), .disp_rdy_r(disp_rdy_r),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .grant(grant), .req(req)
  );

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset;
    disp_valid = 0; disp_tag_l = 0; disp_tag_r = 0; disp_rdy_l = 0; disp_rdy_r = 0;
    bc_valid = 0; bc_tag = 0; grant = 0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic disp(input int tl, input bit rl, input int tr, input bit rr);
    disp_valid = 1; disp_tag_l = TW'(tl); disp_rdy_l = rl;
    disp_tag_r = TW'(tr); disp_rdy_r = rr;
    tick();
    disp_valid = 0; disp_rdy_l = 0; disp_rdy_r = 0;
  endtask

  task automatic bcast(input bit v0, input int t0, input bit v1, input int t1);
    bc_valid = {v1, v0};
    bc_tag = {TW'(t1), TW'(t0)};
    tick();
    bc_valid = 0;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 req", 32'(req), 32'h0);
    chk("R1 disp_ready", 32'(disp_ready), 32'h1);
  endtask

  task automatic t_wake_one;
    do_reset();
    disp(5, 0, 1, 1);
    chk("R5 no req while left pending", 32'(req), 32'h0);
    bcast(0, 0, 1, 5);
    chk("R3 slot1 wakes left", 32'(req), 32'h1);
  endtask

  task automatic t_wake_two_slots;
    do_reset();
    disp(3, 0, 4, 0);
    chk("R2 lands slot0 no req", 32'(req), 32'h0);
    bcast(1, 3, 1, 4);
    chk("R3 both operands one cycle", 32'(req), 32'h1);
  endtask

  task automatic t_sticky;
    do_reset();
    disp(7, 0, 8, 0);
    bcast(1, 7, 0, 0);
    chk("R5 half ready no req", 32'(req), 32'h0);
    tick();
    chk("R4 idle cycle still no req", 32'(req), 32'h0);
    bcast(0, 0, 1, 8);
    chk("R4 left kept ready", 32'(req), 32'h1);
    tick();
    chk("R4 req persists", 32'(req), 32'h1);
  endtask

  task automatic t_invalid_bc;
    do_reset();
    disp(2, 0, 0, 1);
    bcast(0, 2, 0, 2);
    chk("R6 invalid bc ignored", 32'(req), 32'h0);
    bcast(1, 12, 1, 13);
    chk("R3 other tags no match", 32'(req), 32'h0);
    bcast(1, 2, 0, 0);
    chk("R3 slot0 match", 32'(req), 32'h1);
  endtask

  task automatic t_bypass;
    do_reset();
    bc_valid = 2'b01; bc_tag = {TW'(0), TW'(9)};
    disp(9, 0, 0, 1);
    bc_valid = 0;
    chk("R7 dispatch bypass", 32'(req), 32'h1);
    disp(20, 0, 21, 0);
    chk("R2 second to slot1", 32'(req), 32'h1);
    bcast(1, 20, 1, 21);
    chk("R2 slot1 wakes", 32'(req), 32'h3);
  endtask

  task automatic t_grant;
    do_reset();
    disp(0, 1, 0, 1);
    disp(0, 1, 0, 1);
    chk("R5 two ready", 32'(req), 32'h3);
    grant = 16'h0001;
    tick();
    grant = 0;
    chk("R8 slot0 freed", 32'(req), 32'h2);
    disp(0, 1, 0, 1);
    chk("R8 slot0 reused", 32'(req), 32'h3);
  endtask

  task automatic t_grant_idle;
    do_reset();
    disp(11, 0, 0, 1);
    grant = 16'h0001;
    tick();
    grant = 0;
    chk("R9 grant idle no req", 32'(req), 32'h0);
    disp(0, 1, 0, 1);
    chk("R9 slot0 kept, new in slot1", 32'(req), 32'h2);
    bcast(1, 11, 0, 0);
    chk("R9 slot0 still wakes", 32'(req), 32'h3);
  endtask

  task automatic t_full;
    do_reset();
    for (int i = 0; i < N; i++) disp(0, 1, 0, 1);
    chk("R10 all requesting", 32'(req), 32'hFFFF);
    chk("R10 ready low when full", 32'(disp_ready), 32'h0);
    disp_valid = 1; disp_tag_l = 30; disp_rdy_l = 0; disp_tag_r = 31; disp_rdy_r = 0;
    grant = 16'h0020;
    tick();
    grant = 0;
    chk("R10 ready after free", 32'(disp_ready), 32'h1);
    chk("R10 beat dropped", 32'(req), 32'hFFDF);
    disp_valid = 0;
    disp(0, 1, 0, 1);
    chk("R10 refill freed slot", 32'(req), 32'hFFFF);
  endtask

  initial begin
    t_reset();
    t_wake_one();
    t_wake_two_slots();
    t_sticky();
    t_invalid_bc();
    t_bypass();
    t_grant();
    t_grant_idle();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule